// File: doc/BRIEF.md
# Overcurrent Pulse Gate with Frequency Foldback

This block sits between a switching regulator's oscillator and its high-side gate driver. On every oscillator tick it decides whether a conduction pulse may start. Once a pulse starts, it ignores the current comparator for a fixed blanking window. At the last cycle of that window it samples the comparator once. The result of that sample moves a saturating skip counter up or down. After every pulse, the block lets as many oscillator ticks go by unused as the counter holds. Under sustained overload the counter saturates, and the effective switching rate drops to one eighth of nominal.

After blanking, the comparator ends the pulse at once, which gives pulse-by-pulse limiting. A second path selects the peak-limit code for the external current-limit DAC. The full code is used normally. A reduced code (one third of full, never below a floor code that matches the pulse-skip current) is used when feedback has collapsed, but only once soft-start is done. The selection is registered and can change only at a tick taken while no pulse is active.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ocp_pulse_gate`

## Requirements
- R1: While reset is asserted and just after it is released, `gate_on` is 0, `skip_count` is 0, `fold_sel` is 0 and `limit_code` equals the full code `FULL_CODE`.
- R2: A pulse starts only on an `osc_tick` that arrives while idle, with no ticks left to skip and `pwm_demand` high. `gate_on` goes to 1 in the cycle after that tick.
- R3: For the first `BLANK_CYC` cycles of a pulse, `oc_trip` is ignored and `gate_on` stays 1.
- R4: If `oc_trip` is 1 in the last blanking cycle, `gate_on` falls in the next cycle and `skip_count` rises by one. The count saturates at 7 (2^`SKIP_W`-1).
- R5: If `oc_trip` is 0 in the last blanking cycle, `skip_count` falls by one, stopping at 0. The pulse then continues until `pwm_demand` goes low.
- R6: After blanking, `oc_trip` = 1 ends the pulse in the next cycle and leaves `skip_count` unchanged.
- R7: After a pulse ends, exactly `skip_count` ticks go by without a pulse. The next tick may start one.
- R8: `fold_sel` takes the value `fb_low AND ss_done` at each tick that arrives while no pulse is active. At all other times it holds. A value of 1 means the reduced limit is selected, so foldback is inert before soft-start completes.
- R9: `limit_code` is `FULL_CODE` when `fold_sel` = 0. When `fold_sel` = 1 it is the larger of `FULL_CODE`/3 (integer division) and `FLOOR_CODE`.
- R10: A tick with `pwm_demand` low, or a tick that arrives during a pulse, starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse at each oscillator period start |
| pwm_demand | input | 1 | Modulator requests the switch on |
| oc_trip | input | 1 | Current comparator above the selected limit |
| fb_low | input | 1 | Feedback below the fold level |
| ss_done | input | 1 | Soft-start has finished |
| gate_on | output | 1 | Enable to the high-side gate driver |
| skip_count | output | SKIP_W | Present skip count |
| fold_sel | output | 1 | 1 selects the reduced peak limit |
| limit_code | output | CODE_W | Peak-limit code for the limit DAC |

## Verification
The hardest state to reach from the ports is a saturated skip counter, together with its exact skip spacing. Getting there takes seven consecutive pulses, each tripped on precisely the last blanking cycle. Each of those pulses must be preceded by the correct, growing number of idle ticks. The stimulus walks a table of end-of-blanking comparator values. Before each pulse it issues exactly as many ticks as it expects the block to skip, and checks that the gate stays low on every skipped tick. It holds the comparator high through the rest of each blanking window, so the same pass also shows that the comparator is ignored there.

// File: rtl/ocpf_pkg.sv
package ocpf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_COND  = 2'd2
  } gate_st_t;

  function automatic int reduced_code(input int full, input int floor_c);
    int third;
    third = full / 3;
    return (third < floor_c) ? floor_c : third;
  endfunction
endpackage

// File: rtl/ocpf_blank_timer.sv
module ocpf_blank_timer #(
  parameter int BLANK_CYC = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(BLANK_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run)              cnt_q <= '0;
    else if (cnt_q != LAST_V)   cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == LAST_V);

  // R3
  blank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_V);
endmodule

// File: rtl/ocpf_skip_counter.sv
module ocpf_skip_counter #(
  parameter int SKIP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up,
  input  logic              down,
  input  logic              load_gap,
  input  logic              idle_tick,
  output logic [SKIP_W-1:0] count,
  output logic              gap_clear
);
  localparam logic [SKIP_W-1:0] SAT = {SKIP_W{1'b1}};

  logic [SKIP_W-1:0] cnt_q, cnt_d, gap_q;

  always_comb begin
    cnt_d = cnt_q;
    if (up && cnt_q != SAT)        cnt_d = cnt_q + 1'b1;
    else if (down && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (load_gap)                     gap_q <= cnt_d;
      else if (idle_tick && gap_q != '0) gap_q <= gap_q - 1'b1;
    end
  end

  assign count     = cnt_q;
  assign gap_clear = (gap_q == '0);

  // R4 R5
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> ({1'b0, cnt_q} == {1'b0, $past(cnt_q)} + 1'b1) ||
                        ({1'b0, cnt_q} + 1'b1 == {1'b0, $past(cnt_q)}));
  // R7
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= cnt_q);
endmodule

// File: rtl/ocpf_limit_select.sv
module ocpf_limit_select #(
  parameter int CODE_W     = 8,
  parameter int FULL_CODE  = 200,
  parameter int FLOOR_CODE = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update,
  input  logic              fb_low,
  input  logic              ss_done,
  output logic              sel,
  output logic [CODE_W-1:0] code
);
  import ocpf_pkg::*;
  localparam logic [CODE_W-1:0] FULL_V = CODE_W'(FULL_CODE);
  localparam logic [CODE_W-1:0] RED_V  = CODE_W'(reduced_code(FULL_CODE, FLOOR_CODE));
  localparam logic [CODE_W-1:0] FLR_V  = CODE_W'(FLOOR_CODE);

  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (update) sel_q <= fb_low && ss_done;
  end

  assign sel  = sel_q;
  assign code = sel_q ? RED_V : FULL_V;

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(update));
  // R9
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code >= FLR_V);
endmodule

// File: rtl/ocp_pulse_gate.sv
module ocp_pulse_gate #(
  parameter int BLANK_CYC  = 30,
  parameter int SKIP_W     = 3,
  parameter int CODE_W     = 8,
  parameter int FULL_CODE  = 200,
  parameter int FLOOR_CODE = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              pwm_demand,
  input  logic              oc_trip,
  input  logic              fb_low,
  input  logic              ss_done,
  output logic              gate_on,
  output logic [SKIP_W-1:0] skip_count,
  output logic              fold_sel,
  output logic [CODE_W-1:0] limit_code
);
  import ocpf_pkg::*;

  gate_st_t st_q, st_d;
  logic     gate_q;
  logic     blank_last, gap_clear;
  logic     idle_tick, start, trip_blank, pass_blank, end_cond, pulse_end;

  assign idle_tick  = osc_tick && (st_q == ST_IDLE);
  assign start      = idle_tick && gap_clear && pwm_demand;
  assign trip_blank = blank_last && oc_trip;
  assign pass_blank = blank_last && !oc_trip;
  assign end_cond   = (st_q == ST_COND) && (oc_trip || !pwm_demand);
  assign pulse_end  = trip_blank || end_cond;

  ocpf_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st_q == ST_BLANK),
    .last (blank_last)
  );

  ocpf_skip_counter #(.SKIP_W(SKIP_W)) u_skip (
    .clk      (clk),
    .rst_n    (rst_n),
    .up       (trip_blank),
    .down     (pass_blank),
    .load_gap (pulse_end),
    .idle_tick(idle_tick),
    .count    (skip_count),
    .gap_clear(gap_clear)
  );

  ocpf_limit_select #(
    .CODE_W(CODE_W), .FULL_CODE(FULL_CODE), .FLOOR_CODE(FLOOR_CODE)
  ) u_lim (
    .clk    (clk),
    .rst_n  (rst_n),
    .update (idle_tick),
    .fb_low (fb_low),
    .ss_done(ss_done),
    .sel    (fold_sel),
    .code   (limit_code)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_BLANK;
      ST_BLANK: if (blank_last) st_d = oc_trip ? ST_IDLE : ST_COND;
      ST_COND:  if (end_cond) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      gate_q <= (st_d != ST_IDLE);
    end
  end

  assign gate_on = gate_q;

  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(osc_tick) && $past(pwm_demand));
  // R3
  no_blank_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_on) |-> ($past(st_q) == ST_COND) || $past(blank_last));
  // R8
  sel_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fold_sel) |-> $past(st_q) == ST_IDLE);
  // R10
  idle_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !gate_on);
endmodule

// File: tb/sim_ocp_pulse_gate.sv
module sim_ocp_pulse_gate;
  localparam int B = 30;
  localparam int NV = 16;
  // {oc at end of blanking, expected count after pulse}
  localparam logic [3:0] VEC [NV] = '{
    4'b1_001, 4'b1_010, 4'b1_011, 4'b1_100, 4'b1_101, 4'b1_110, 4'b1_111, 4'b1_111,
    4'b0_110, 4'b0_101, 4'b0_100, 4'b0_011, 4'b0_010, 4'b0_001, 4'b0_000, 4'b0_000};

  logic clk = 0, rst_n = 0;
  logic osc_tick = 0, pwm_demand = 0, oc_trip = 0, fb_low = 0, ss_done = 0;
  logic gate_on, fold_sel, gate1, sel1;
  logic [2:0] skip_count, skip1;
  logic [7:0] limit_code, code1;
  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ocp_pulse_gate #(.BLANK_CYC(B)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pwm_demand(pwm_demand),
    .oc_trip(oc_trip), .fb_low(fb_low), .ss_done(ss_done), .gate_on(gate_on),
    .skip_count(skip_count), .fold_sel(fold_sel), .limit_code(limit_code));

  ocp_pulse_gate #(.BLANK_CYC(B), .FULL_CODE(60), .FLOOR_CODE(25)) u1 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pwm_demand(pwm_demand),
    .oc_trip(oc_trip), .fb_low(fb_low), .ss_done(ss_done), .gate_on(gate1),
    .skip_count(skip1), .fold_sel(sel1), .limit_code(code1));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) osc_tick = 1;
    @(negedge clk) osc_tick = 0;
  endtask

  task automatic run_pulse(input bit oc_end, input int prev, input int exp);
    for (int k = 0; k <= prev; k++) begin
      tick_once();
      if (k < prev) chk("R7 skipped tick", gate_on, 0);
      else          chk("R2 pulse start", gate_on, 1);
    end
    oc_trip = 1;
    repeat (B - 2) @(negedge clk);
    @(negedge clk);
    chk("R3 blanking ignores trip", gate_on, 1);
    oc_trip = oc_end;
    @(negedge clk);
    chk(oc_end ? "R4 count up" : "R5 count down", skip_count, exp);
    chk(oc_end ? "R4 gate off" : "R5 pulse continues", gate_on, oc_end ? 0 : 1);
    oc_trip = 0;
    if (!oc_end) begin
      pwm_demand = 0;
      @(negedge clk);
      chk("R5 ends on demand low", gate_on, 0);
      pwm_demand = 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int prev;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 gate", gate_on, 0);
    chk("R1 count", skip_count, 0);
    chk("R1 sel", fold_sel, 0);
    chk("R1 code", limit_code, 200);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", gate_on, 0);

    pwm_demand = 1;
    prev = 0;
    for (int i = 0; i < NV; i++) begin
      run_pulse(VEC[i][3], prev, int'(VEC[i][2:0]));
      prev = int'(VEC[i][2:0]);
    end

    // R6: trip after blanking
    run_pulse(1'b1, 0, 1);
    tick_once();
    chk("R7 one skip", gate_on, 0);
    tick_once();
    chk("R2 restart", gate_on, 1);
    repeat (B + 2) @(negedge clk);
    chk("R5 in conduction", skip_count, 0);
    oc_trip = 1;
    @(negedge clk);
    chk("R6 gate off", gate_on, 0);
    chk("R6 count held", skip_count, 0);
    oc_trip = 0;

    // R10: no pulse without demand
    pwm_demand = 0;
    tick_once();
    chk("R10 no demand", gate_on, 0);

    // R8: foldback blocked before soft-start
    fb_low = 1;
    tick_once();
    chk("R8 ss not done", fold_sel, 0);
    chk("R9 full code", limit_code, 200);
    ss_done = 1;
    repeat (3) @(negedge clk);
    chk("R8 holds w/o tick", fold_sel, 0);
    tick_once();
    chk("R8 fold", fold_sel, 1);
    chk("R9 third", limit_code, 66);
    chk("R9 floor", code1, 25);

    // R10/R8: tick during pulse ignored
    pwm_demand = 1;
    tick_once();
    chk("R2 start", gate_on, 1);
    fb_low = 0;
    tick_once();
    chk("R8 held in pulse", fold_sel, 1);
    repeat (B + 2) @(negedge clk);
    chk("R10 no restart", gate_on, 1);
    pwm_demand = 0;
    @(negedge clk);
    chk("R5 end", gate_on, 0);
    tick_once();
    chk("R8 restore", fold_sel, 0);
    chk("R9 restore", limit_code, 200);

    // R1: reset clears a raised count
    pwm_demand = 1;
    run_pulse(1'b1, 0, 1);
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset count", skip_count, 0);
    rst_n = 1;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule